// File: doc/BRIEF.md
# Interrupt Destination Acceptance Unit

This unit sits on the receive side of one processor's interrupt controller. It decides whether an interrupt message seen on the shared delivery path is meant for this processor. Each message carries a destination byte and a mode bit. When the mode bit selects physical addressing, the byte is compared with the processor's hard ID. When it selects logical addressing, the byte is matched against a programmable logical ID. The match follows one of two grouping models, set by a 4-bit model code.

In the flat model, every destination bit stands for one processor, so up to eight processors can be addressed, and any overlap with the logical ID is a hit. In the cluster model, the upper nibble names a group and the lower nibble is a member bitmap within that group. An all-ones destination reaches every unit whatever the mode.

The logical ID and the model code are loaded through a 32-bit write port. The verdict comes out as a registered accept flag one cycle after the message is presented.

Top module: `dest_accept_unit`

## Requirements
- R1: After reset, the model code is 1111b (flat model) and the logical ID is 0x00. Accept is low out of reset.
- R2: With msg_logical=0, a valid message is accepted exactly when msg_dest equals local_id, or when msg_dest is 0xFF.
- R3: With msg_logical=1 and model 1111b, a valid message is accepted exactly when (msg_dest AND logical ID) is nonzero, or when msg_dest is 0xFF. local_id plays no part.
- R4: With msg_logical=1 and model 0000b, bits [7:4] are the cluster and bits [3:0] the member bitmap. A valid message is accepted exactly when both cluster fields are equal and both member bitmaps share a set bit, or when msg_dest is 0xFF.
- R5: A destination of 0xFF is accepted in both modes and under every model code, including unsupported codes.
- R6: With msg_logical=1 and a model code other than 1111b or 0000b, every valid message whose destination is not 0xFF is rejected.
- R7: A write with cfg_sel=0 loads the logical ID from cfg_wdata[31:24]. A write with cfg_sel=1 loads the model code from cfg_wdata[31:28]. All other data bits are ignored. A written value governs messages presented from the next cycle on.
- R8: accept is registered. It reflects the message presented on the previous clock edge, and it is low in any cycle after which msg_valid was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = logical ID register, 1 = model register |
| cfg_wdata | input | 32 | Register write data |
| msg_valid | input | 1 | A message is presented this cycle |
| msg_logical | input | 1 | 1 = logical addressing, 0 = physical |
| msg_dest | input | 8 | Destination byte of the message |
| local_id | input | 8 | Hard physical ID of this processor |
| accept | output | 1 | Registered verdict for the previous cycle's message |

## Verification
The assertions assume that reset is released synchronously to the clock. They also assume that a message and a register write presented in the same cycle are judged against the old register value; the bench never overlaps the two. The bench drives all inputs on the falling edge, so every input is stable across the rising edge. It programs both registers before each table entry and presents each message for exactly one cycle, followed by an idle cycle. That keeps every registered accept tied to a single known message and a single known configuration.

// File: rtl/dest_accept_pkg.sv
package dest_accept_pkg;
    localparam int unsigned DA_REG_W   = 32;
    localparam int unsigned DA_DEST_W  = 8;
    localparam int unsigned DA_MODEL_W = 4;
    localparam int unsigned DA_GROUP_W = 4;

    localparam logic [DA_MODEL_W-1:0] DA_MODEL_FLAT    = '1;
    localparam logic [DA_MODEL_W-1:0] DA_MODEL_CLUSTER = '0;

    typedef struct packed {
        logic [DA_DEST_W-1:0]  lid;
        logic [DA_MODEL_W-1:0] model;
    } da_cfg_t;

    typedef struct packed {
        logic accept;
    } da_state_t;
endpackage

// File: rtl/da_cfg_regs.sv
module da_cfg_regs
    import dest_accept_pkg::*;
#(
    parameter int unsigned REG_W   = DA_REG_W,
    parameter int unsigned DEST_W  = DA_DEST_W,
    parameter int unsigned MODEL_W = DA_MODEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic               sel,
    input  logic [REG_W-1:0]   wdata,
    output logic [DEST_W-1:0]  lid,
    output logic [MODEL_W-1:0] model
);
    localparam int unsigned LID_LSB   = REG_W - DEST_W;
    localparam int unsigned MODEL_LSB = REG_W - MODEL_W;

    da_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            if (!sel) cfg_d.lid   = wdata[REG_W-1:LID_LSB];
            else      cfg_d.model = wdata[REG_W-1:MODEL_LSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.lid   <= '0;
            cfg_q.model <= DA_MODEL_FLAT;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign lid   = cfg_q.lid;
    assign model = cfg_q.model;

    logic unused_low_bits;
    assign unused_low_bits = ^wdata[LID_LSB-1:0];

    p_lid_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !sel |=> lid == $past(wdata[REG_W-1:LID_LSB]));
    p_model_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr && sel |=> model == $past(wdata[REG_W-1:MODEL_LSB]));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(lid) && $stable(model));
endmodule

// File: rtl/da_logical_match.sv
module da_logical_match
    import dest_accept_pkg::*;
#(
    parameter int unsigned DEST_W  = DA_DEST_W,
    parameter int unsigned GROUP_W = DA_GROUP_W,
    parameter int unsigned MODEL_W = DA_MODEL_W
) (
    input  logic [DEST_W-1:0]  dest,
    input  logic [DEST_W-1:0]  lid,
    input  logic [MODEL_W-1:0] model,
    output logic               hit
);
    localparam int unsigned MEMBER_W = DEST_W - GROUP_W;

    logic [DEST_W-1:0] bit_hit;
    logic              flat_hit;
    logic              group_eq;
    logic              member_hit;

    for (genvar i = 0; i < DEST_W; i++) begin : g_bit
        assign bit_hit[i] = dest[i] & lid[i];
    end

    assign flat_hit   = |bit_hit;
    assign group_eq   = dest[DEST_W-1:MEMBER_W] == lid[DEST_W-1:MEMBER_W];
    assign member_hit = |bit_hit[MEMBER_W-1:0];

    always_comb begin
        if (model == DA_MODEL_FLAT)         hit = flat_hit;
        else if (model == DA_MODEL_CLUSTER) hit = group_eq && member_hit;
        else                                hit = 1'b0;
    end
endmodule

// File: rtl/da_physical_match.sv
module da_physical_match #(
    parameter int unsigned DEST_W = 8
) (
    input  logic [DEST_W-1:0] dest,
    input  logic [DEST_W-1:0] local_id,
    output logic              hit
);
    assign hit = dest == local_id;
endmodule

// File: rtl/dest_accept_unit.sv
module dest_accept_unit
    import dest_accept_pkg::*;
#(
    parameter int unsigned REG_W   = DA_REG_W,
    parameter int unsigned DEST_W  = DA_DEST_W,
    parameter int unsigned MODEL_W = DA_MODEL_W,
    parameter int unsigned GROUP_W = DA_GROUP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              msg_valid,
    input  logic              msg_logical,
    input  logic [DEST_W-1:0] msg_dest,
    input  logic [DEST_W-1:0] local_id,
    output logic              accept
);
    logic [DEST_W-1:0]  lid;
    logic [MODEL_W-1:0] model;
    logic               log_hit;
    logic               phys_hit;
    logic               bcast;

    da_cfg_regs #(.REG_W(REG_W), .DEST_W(DEST_W), .MODEL_W(MODEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel),
        .wdata(cfg_wdata), .lid(lid), .model(model)
    );

    da_logical_match #(.DEST_W(DEST_W), .GROUP_W(GROUP_W), .MODEL_W(MODEL_W)) u_log (
        .dest(msg_dest), .lid(lid), .model(model), .hit(log_hit)
    );

    da_physical_match #(.DEST_W(DEST_W)) u_phys (
        .dest(msg_dest), .local_id(local_id), .hit(phys_hit)
    );

    assign bcast = &msg_dest;

    da_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.accept = msg_valid && (bcast || (msg_logical ? log_hit : phys_hit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign accept = st_q.accept;

    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |=> !accept);
    p_bcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && (msg_dest == '1) |=> accept);
    p_phys_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_logical && (msg_dest != '1) && (msg_dest != local_id) |=> !accept);
    p_phys_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_logical && (msg_dest == local_id) |=> accept);
    p_bad_model_r6: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_logical && (msg_dest != '1) && (model != DA_MODEL_FLAT)
        && (model != DA_MODEL_CLUSTER) |=> !accept);
    p_flat_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_logical && (model == DA_MODEL_FLAT) && (msg_dest != '1)
        && ((msg_dest & lid) == '0) |=> !accept);
endmodule

// File: tb/tb_dest_accept_unit.sv
module tb_dest_accept_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;

    // {lid[8], model[4], logical[1], dest[8], local_id[8], expect[1]}
    localparam logic [29:0] VEC [NVEC] = '{
        {8'h00, 4'hF, 1'b0, 8'h05, 8'h05, 1'b1},  // R2 equal
        {8'h00, 4'hF, 1'b0, 8'h05, 8'h06, 1'b0},  // R2 differ
        {8'h05, 4'hF, 1'b0, 8'h80, 8'h80, 1'b1},  // R2 high id
        {8'hFF, 4'hF, 1'b0, 8'h01, 8'h02, 1'b0},  // R2 lid ignored
        {8'h24, 4'hF, 1'b1, 8'h04, 8'h00, 1'b1},  // R3 overlap
        {8'h24, 4'hF, 1'b1, 8'h81, 8'h81, 1'b0},  // R3 no overlap
        {8'h80, 4'hF, 1'b1, 8'h80, 8'h00, 1'b1},  // R3 top bit
        {8'h00, 4'hF, 1'b1, 8'h7F, 8'h7F, 1'b0},  // R3 zero lid
        {8'h01, 4'hF, 1'b1, 8'h02, 8'h02, 1'b0},  // R3 local_id ignored
        {8'h32, 4'h0, 1'b1, 8'h36, 8'h00, 1'b1},  // R4 same cluster overlap
        {8'h32, 4'h0, 1'b1, 8'h31, 8'h00, 1'b0},  // R4 no member overlap
        {8'h32, 4'h0, 1'b1, 8'h42, 8'h00, 1'b0},  // R4 other cluster
        {8'h3F, 4'h0, 1'b1, 8'h30, 8'h00, 1'b0},  // R4 empty member map
        {8'h12, 4'h0, 1'b1, 8'h22, 8'h00, 1'b0},  // R4 flat would hit
        {8'h00, 4'h0, 1'b1, 8'h01, 8'h00, 1'b0},  // R4 cluster 0 empty
        {8'h00, 4'hF, 1'b0, 8'hFF, 8'h03, 1'b1},  // R5 physical
        {8'h00, 4'hF, 1'b1, 8'hFF, 8'h00, 1'b1},  // R5 flat
        {8'h12, 4'h0, 1'b1, 8'hFF, 8'h00, 1'b1},  // R5 cluster
        {8'h00, 4'h5, 1'b1, 8'hFF, 8'h00, 1'b1},  // R5 bad model
        {8'hFF, 4'h5, 1'b1, 8'h01, 8'h00, 1'b0},  // R6 code 5
        {8'h11, 4'h8, 1'b1, 8'h11, 8'h00, 1'b0},  // R6 code 8
        {8'h11, 4'h7, 1'b1, 8'h10, 8'h10, 1'b0}   // R6 code 7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        msg_valid = 1'b0;
    logic        msg_logical = 1'b0;
    logic [7:0]  msg_dest = '0;
    logic [7:0]  local_id = '0;
    logic        accept;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    dest_accept_unit dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .msg_valid(msg_valid), .msg_logical(msg_logical),
        .msg_dest(msg_dest), .local_id(local_id), .accept(accept)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: accept=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    // presents one message, returns the accept sampled one edge later
    task automatic send(input logic lg, input logic [7:0] d, input logic [7:0] lid_in,
                        output logic got);
        msg_valid = 1'b1; msg_logical = lg; msg_dest = d; local_id = lid_in;
        @(negedge clk);
        got = accept;
        msg_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic got;
        repeat (3) @(negedge clk);
        check("R1 reset accept", accept, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: lid resets to zero, so a logical non-broadcast misses
        send(1'b1, 8'h01, 8'h01, got);
        check("R1 lid zero", got, 1'b0);
        // R1: model resets flat; only lid written, low bits junk (R7)
        write_reg(1'b0, 32'h01FF_FFFF);
        send(1'b1, 8'h01, 8'h00, got);
        check("R1 flat default / R7 lid field", got, 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            write_reg(1'b0, {VEC[i][29:22], 24'hA5C3_5A});
            write_reg(1'b1, {VEC[i][21:18], 28'h5A5_A5A5});
            @(negedge clk);
            send(VEC[i][17], VEC[i][16:9], VEC[i][8:1], got);
            if (got !== VEC[i][0]) $display("  vector %0d", i);
            check("table R2-R6", got, VEC[i][0]);
        end

        // R8: broadcast destination but msg_valid low -> no accept
        msg_valid = 1'b0; msg_dest = 8'hFF;
        @(negedge clk);
        check("R8 idle", accept, 1'b0);
        // R8: accept drops the cycle after a one-cycle message
        send(1'b0, 8'hFF, 8'h00, got);
        check("R8 pulse", got, 1'b1);
        check("R8 release", accept, 1'b0);
        // R7: model register ignores bits below 31:28
        write_reg(1'b0, 32'h3200_0000);
        write_reg(1'b1, 32'h0FFF_FFFF);
        send(1'b1, 8'h22, 8'h00, got);
        check("R7 model field", got, 1'b0);
        send(1'b1, 8'h32, 8'h00, got);
        check("R7 cluster hit", got, 1'b1);
        // R7: write takes effect for next-cycle message
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'hF000_0000;
        @(negedge clk);
        cfg_wr = 1'b0;
        send(1'b1, 8'h22, 8'h00, got);
        check("R7 next cycle", got, 1'b1);
        // R1: reset again restores defaults
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset accept again", accept, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        send(1'b1, 8'h32, 8'h00, got);
        check("R1 lid cleared", got, 1'b0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: done=0 expected=1");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule